// File: doc/BRIEF.md
# Multi-Cycle Byte-Addressable Word Memory

This block is a 16-bit, word-organized storage array that a multi-cycle processor reaches through its address and data registers. A requester raises the enable, chooses read or write and word or byte size, and holds the request steady. The block counts how many consecutive cycles the request has been held. It raises the ready bit only in the last cycle of a fixed latency, and five cycles is the default. Between requests the requester must drop enable, or else treat the cycle after ready as the first cycle of a new access.

The array is word aligned. Address bit 0 picks a byte lane for byte accesses and has no effect on word accesses. A byte store changes only the selected half of the addressed word. A byte load returns the selected half sign-extended to 16 bits. The word index is the address shifted right by one, taken modulo the depth, so addresses past the end wrap. Reset clears the whole array.

The sequencer uses three named states. `ST_IDLE` is the first presented cycle, with the count at zero. `ST_COUNT` covers the middle cycles, in which the count advances. `ST_FINAL` is the last cycle, in which ready and any write happen. The transitions are: `ST_IDLE -> ST_COUNT` when enable is high (or `ST_IDLE -> ST_FINAL` when the latency is 2), `ST_COUNT -> ST_COUNT` while enable holds and the count has not reached its limit, `ST_COUNT -> ST_FINAL` when it has, `ST_COUNT -> ST_IDLE` when enable drops, and `ST_FINAL -> ST_IDLE` always.

Top module: `mcyc_mem`

## Requirements
- R1: After reset, ready is low, rdata is zero, and every word of the array reads back as zero.
- R2: With enable held, ready is high only in the fifth consecutive cycle of the request (LAT, default 5) and is low in cycles one to four. If enable stays high after ready, the next ready comes another LAT cycles later.
- R3: Dropping enable before ready restarts the count, so the next request again needs LAT full cycles.
- R4: A write changes the array only in its ready cycle. A write abandoned before ready leaves the addressed word unchanged.
- R5: A word read (req_byte=0) returns the whole word at the aligned address, whatever the value of addr[0].
- R6: A word write (req_byte=0) stores all 16 bits of wdata at the aligned address, whatever the value of addr[0].
- R7: A byte write (req_byte=1) stores wdata[7:0] into bits [15:8] when addr[0]=1, or into bits [7:0] when addr[0]=0, and leaves the other byte of the word unchanged.
- R8: A byte read returns bits [15:8] when addr[0]=1, or bits [7:0] when addr[0]=0, sign-extended from bit 7 of that byte to 16 bits.
- R9: The word index is (addr >> 1) modulo DEPTH, default 64, so addr and addr + 2*DEPTH reach the same word.
- R10: rdata is zero in every cycle where ready is low and in the ready cycle of a write. It carries read data only in the ready cycle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_en | input | 1 | Request enable, held until ready |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| addr | input | 16 | Byte address; bit 0 selects the lane for byte accesses |
| wdata | input | 16 | Write data; bits [7:0] are the source for byte writes |
| rdata | output | 16 | Read result, valid in the ready cycle of a read |
| ready | output | 1 | High in the last cycle of the access |

## Verification
The hardest case to reach from the ports is a write that is held for all but its final cycle and then withdrawn. Only the missing ready cycle separates that write from one that commits. The stimulus holds a write for LAT-1 cycles, drops enable, and then reads the word back to confirm it kept its earlier value. A second directed case drops enable midway and checks that the following access still takes the full latency. Seeded random accesses span the whole 16-bit address range, so wrapped indices and both byte lanes mix with word traffic, and every result is checked against a shadow model kept in the bench.

// File: rtl/mcm_pkg.sv
package mcm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FINAL = 2'd2
    } mcm_state_t;

endpackage

// File: rtl/mcm_seq.sv
module mcm_seq
    import mcm_pkg::*;
#(
    parameter int LAT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic ready
);

    localparam int CW = (LAT > 2) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] MID_LAST = CW'(LAT - 2);

    mcm_state_t     state, state_nxt;
    logic [CW-1:0]  cnt, cnt_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                cnt_nxt = '0;
                if (en) begin
                    cnt_nxt   = CW'(1);
                    state_nxt = (LAT == 2) ? ST_FINAL : ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (!en) begin
                    state_nxt = ST_IDLE;
                    cnt_nxt   = '0;
                end else if (cnt == MID_LAST) begin
                    state_nxt = ST_FINAL;
                end else begin
                    cnt_nxt = cnt + CW'(1);
                end
            end
            ST_FINAL: begin
                state_nxt = ST_IDLE;
                cnt_nxt   = '0;
            end
            default: begin
                state_nxt = ST_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        ready = (state == ST_FINAL) && en;
    end

endmodule

// File: rtl/mcm_lanes.sv
module mcm_lanes #(
    parameter int DW = 16
) (
    input  logic          byte_op,
    input  logic          hi_sel,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] word_in,
    output logic [DW-1:0] wr_word,
    output logic [1:0]    wr_mask,
    output logic [DW-1:0] rd_val
);

    localparam int BW = DW / 2;

    logic [BW-1:0] picked;

    always_comb begin
        if (byte_op) begin
            wr_word = {wdata[BW-1:0], wdata[BW-1:0]};
            wr_mask = hi_sel ? 2'b10 : 2'b01;
        end else begin
            wr_word = wdata;
            wr_mask = 2'b11;
        end
    end

    always_comb begin
        picked = hi_sel ? word_in[DW-1:BW] : word_in[BW-1:0];
        if (byte_op) rd_val = {{BW{picked[BW-1]}}, picked};
        else         rd_val = word_in;
    end

endmodule

// File: rtl/mcm_array.sv
module mcm_array #(
    parameter int DEPTH = 64,
    parameter int DW    = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    mask,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int BW = DW / 2;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [BW-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) lane_mem[i] <= '0;
            end else if (we && mask[g]) begin
                lane_mem[idx] <= wdata[g*BW +: BW];
            end
        end

        assign rdata[g*BW +: BW] = lane_mem[idx];
    end

endmodule

// File: rtl/mcyc_mem.sv
module mcyc_mem #(
    parameter int LAT   = 5,
    parameter int DEPTH = 64,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_en,
    input  logic          req_wr,
    input  logic          req_byte,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          ready
);

    localparam int IW = $clog2(DEPTH);

    logic [IW-1:0] idx;
    logic [DW-1:0] store_word;
    logic [DW-1:0] merged_word;
    logic [1:0]    lane_mask;
    logic [DW-1:0] shaped;
    logic          commit;

    assign idx    = IW'((addr >> 1) % DEPTH);
    assign commit = ready && req_wr;

    mcm_seq #(.LAT(LAT)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (req_en),
        .ready (ready)
    );

    mcm_lanes #(.DW(DW)) u_lanes (
        .byte_op (req_byte),
        .hi_sel  (addr[0]),
        .wdata   (wdata),
        .word_in (store_word),
        .wr_word (merged_word),
        .wr_mask (lane_mask),
        .rd_val  (shaped)
    );

    mcm_array #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .mask  (lane_mask),
        .idx   (idx),
        .wdata (merged_word),
        .rdata (store_word)
    );

    assign rdata = (ready && !req_wr) ? shaped : '0;

endmodule

// File: rtl/mcyc_mem_chk.sv
module mcyc_mem_chk #(
    parameter int LAT = 5,
    parameter int DW  = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_en,
    input logic          req_wr,
    input logic          ready,
    input logic [DW-1:0] rdata
);

    logic [7:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n)              run <= '0;
        else if (!req_en || ready) run <= '0;
        else                     run <= run + 8'd1;
    end

    p_ready_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> req_en);

    p_ready_at_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (run == 8'(LAT - 1)));

    p_ready_when_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && run == 8'(LAT - 1)) |-> ready);

    p_no_back_to_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_en |=> !ready);

    p_rdata_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready || req_wr) |-> (rdata == '0));

endmodule

bind mcyc_mem mcyc_mem_chk #(.LAT(LAT), .DW(DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_en (req_en),
    .req_wr (req_wr),
    .ready  (ready),
    .rdata  (rdata)
);

// File: tb/mcyc_mem_tb.sv
`timescale 1ns/1ps
module mcyc_mem_tb;

    localparam int LAT   = 5;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_en = 1'b0, req_wr = 1'b0, req_byte = 1'b0;
    logic [15:0] addr = '0, wdata = '0;
    logic [15:0] rdata;
    logic        ready;

    int tests = 0, fails = 0;
    logic [15:0] shadow [DEPTH];

    always #4 clk = ~clk;

    mcyc_mem #(.LAT(LAT), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_wr(req_wr),
        .req_byte(req_byte), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ready(ready)
    );

    function automatic int widx(input logic [15:0] a);
        return int'(a >> 1) % DEPTH;
    endfunction

    function automatic logic [15:0] exp_read(input logic byt, input logic [15:0] a);
        logic [15:0] w = shadow[widx(a)];
        logic [7:0]  b = a[0] ? w[15:8] : w[7:0];
        return byt ? {{8{b[7]}}, b} : w;
    endfunction

    function automatic void model_write(input logic byt, input logic [15:0] a, input logic [15:0] d);
        if (!byt)      shadow[widx(a)] = d;
        else if (a[0]) shadow[widx(a)][15:8] = d[7:0];
        else           shadow[widx(a)][7:0]  = d[7:0];
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic byt, input logic [15:0] a,
                          input logic [15:0] d, output logic [15:0] rd, output int cyc);
        int quiet_bad = 0;
        @(negedge clk);
        req_en = 1'b1; req_wr = wr; req_byte = byt; addr = a; wdata = d;
        cyc = 0; rd = '0;
        forever begin
            #1;
            cyc++;
            if (ready) begin rd = rdata; break; end
            if (rdata !== 16'h0) quiet_bad++;
            if (cyc > 20) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_en = 1'b0;
        if (quiet_bad != 0) chk("R10 rdata nonzero while waiting", 16'(quiet_bad), 16'h0);
        if (wr) model_write(byt, a, d);
    endtask

    // read and compare with model, also check the latency
    task automatic rd_chk(input string tag, input logic byt, input logic [15:0] a);
        logic [15:0] rd, exp;
        int cyc;
        exp = exp_read(byt, a);
        access(1'b0, byt, a, 16'h0, rd, cyc);
        chk({tag, " data"}, rd, exp);
        chk("R2 latency", 16'(cyc), 16'(LAT));
    endtask

    task automatic wr_do(input logic byt, input logic [15:0] a, input logic [15:0] d);
        logic [15:0] rd;
        int cyc;
        access(1'b1, byt, a, d, rd, cyc);
        chk("R2 write latency", 16'(cyc), 16'(LAT));
        chk("R10 rdata on write", rd, 16'h0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [9:0] seen;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 ready after reset", {15'h0, ready}, 16'h0);
        chk("R1 rdata after reset", rdata, 16'h0);
        rd_chk("R1 cleared word", 1'b0, 16'h0022);
        rd_chk("R1 cleared word high", 1'b0, 16'h007E);

        // R2 enable held across two accesses
        @(negedge clk);
        req_en = 1'b1; req_wr = 1'b0; req_byte = 1'b0; addr = 16'h0004;
        seen = '0;
        for (int i = 0; i < 10; i++) begin
            #1; seen[i] = ready;
            @(negedge clk);
        end
        req_en = 1'b0;
        chk("R2 ready pattern held enable", {6'h0, seen}, 16'b10_0001_0000);

        // R5 / R6 word access ignores addr[0]
        wr_do(1'b0, 16'h0011, 16'hBEEF);
        rd_chk("R6 word write at odd address", 1'b0, 16'h0010);
        rd_chk("R5 word read at odd address", 1'b0, 16'h0011);

        // R3 restart after early drop
        @(negedge clk);
        req_en = 1'b1; req_wr = 1'b0; addr = 16'h0010;
        repeat (3) begin #1; chk("R3 no ready before drop", {15'h0, ready}, 16'h0); @(negedge clk); end
        req_en = 1'b0;
        rd_chk("R3 full latency after restart", 1'b0, 16'h0010);

        // R4 abandoned write leaves memory unchanged
        @(negedge clk);
        req_en = 1'b1; req_wr = 1'b1; req_byte = 1'b0; addr = 16'h0010; wdata = 16'h0000;
        repeat (LAT - 1) begin #1; chk("R4 no ready in abandoned write", {15'h0, ready}, 16'h0); @(negedge clk); end
        req_en = 1'b0; req_wr = 1'b0;
        rd_chk("R4 word kept after abandoned write", 1'b0, 16'h0010);

        // R7 byte stores into each lane
        wr_do(1'b0, 16'h0020, 16'h1234);
        wr_do(1'b1, 16'h0021, 16'hFFA5);
        rd_chk("R7 high lane store", 1'b0, 16'h0020);
        wr_do(1'b1, 16'h0020, 16'h005A);
        rd_chk("R7 low lane store", 1'b0, 16'h0020);

        // R8 byte loads with sign extension
        wr_do(1'b0, 16'h0030, 16'h7F80);
        rd_chk("R8 low byte negative", 1'b1, 16'h0030);
        rd_chk("R8 high byte positive", 1'b1, 16'h0031);
        chk("R8 directed low value", exp_read(1'b1, 16'h0030), 16'hFF80);

        // R9 wrap modulo depth
        wr_do(1'b0, 16'h0006 + 16'(2 * DEPTH), 16'hC0DE);
        rd_chk("R9 wrapped alias", 1'b0, 16'h0006);
        rd_chk("R9 wrapped far alias", 1'b0, 16'hFF86);

        // random traffic, R5 R6 R7 R8 R9
        for (int n = 0; n < 150; n++) begin
            logic [15:0] a = 16'($urandom);
            logic        byt = 1'($urandom);
            if ($urandom % 2) wr_do(byt, a, 16'($urandom));
            else              rd_chk("R8 R5 random read", byt, a);
        end
        for (int i = 0; i < 8; i++) rd_chk("R9 R6 final sweep", 1'b0, 16'(i * 2));

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule